// File: doc/BRIEF.md
# Split-Tag Address Translation Buffer

This block translates virtual addresses to physical ones for 4 KiB pages. It uses a direct-mapped buffer of page translations. One array holds the physical frame of each slot. Three separate tag arrays sit over it, each with its own valid bits: one for instruction fetches, one for loads and one for stores. A slot can therefore translate a page for reads while refusing writes or execution to the same page.

A lookup presents a virtual address and its access kind. One cycle later the block answers with a hit and the physical address, or with a miss. A miss is remembered as the single pending miss; a later miss replaces it. The page-table walk is done elsewhere. When the walker delivers the page-table entry on the refill port, together with the current privilege mode, the block does two things:

- It writes the frame into the pending miss's slot and grants each access kind its tag according to the entry's permission bits.
- It reports whether the kind that missed completed, with its physical address, or faulted.

Writing the page-table base register aligns the value to a page boundary and invalidates every translation.

Top module: `tlb_xlate`

## Requirements
- R1: After reset, rsp_hit, rsp_miss, rf_done and rf_fault are 0 and ptb_q is 0. Every slot is invalid for all three access kinds, so any lookup misses.
- R2: The slot used is vaddr[19:12] (256 slots). A lookup hits only when the selected kind's tag in that slot is valid and equals vaddr[63:12]. Two addresses that share bits 19:12 but differ above them do not hit on each other's translation.
- R3: The tag array is chosen by access kind, in this priority: lk_fetch=1 uses the fetch tags even when lk_store is also 1; lk_fetch=0 with lk_store=1 uses the store tags; both 0 uses the load tags.
- R4: On a hit, rsp_paddr is the slot's frame (pte bits 63:12) concatenated with vaddr[11:0]. The response appears in the cycle after lk_valid.
- R5: On a miss, rsp_miss is 1 in the cycle after lk_valid, and the address and kind become the pending miss.
- R6: A refill writes pte[63:12] as the frame of the pending miss's slot. For each of the three kinds it then sets that kind's tag when the permission bits allow it and invalidates it otherwise. The permission bits are pte bit 4 user execute, bit 5 user write, bit 6 user read, bit 7 supervisor execute, bit 8 supervisor write and bit 9 supervisor read. rf_supervisor picks the upper three bits. Fetch needs execute, store needs write and load needs read.
- R7: In the cycle after a refill, rf_done is 1 with rf_paddr = {pte[63:12], vaddr[11:0]} of the pending miss if its kind is allowed. Otherwise rf_fault is 1. The refill clears the pending miss.
- R8: A refill with no pending miss is ignored: no rf_done or rf_fault, and no slot changes.
- R9: A write on ptb_we sets ptb_q to ptb_wdata with bits 11:0 cleared, and invalidates all tags of all kinds.
- R10: A lookup sees the buffer as it was before the clock edge that samples it. A refill or a flush in the same cycle affects only later lookups.
- R11: When a flush and a refill share a cycle, the flush wins: no tag is set. The refill's done or fault response is still reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 64 | Lookup virtual address |
| lk_fetch | input | 1 | Lookup is an instruction fetch |
| lk_store | input | 1 | Lookup is a store |
| rsp_hit | output | 1 | Lookup hit, one cycle after request |
| rsp_miss | output | 1 | Lookup missed, one cycle after request |
| rsp_paddr | output | 64 | Physical address on hit |
| rf_valid | input | 1 | Refill entry present |
| rf_pte | input | 64 | Page-table entry for the pending miss |
| rf_supervisor | input | 1 | Privilege mode: 1 supervisor, 0 user |
| rf_done | output | 1 | Pending access completed after refill |
| rf_fault | output | 1 | Pending access not permitted |
| rf_paddr | output | 64 | Physical address of completed access |
| ptb_we | input | 1 | Page-table base write, flushes buffer |
| ptb_wdata | input | 64 | Page-table base write value |
| ptb_q | output | 64 | Current page-table base |

## Verification
Two collisions are the focus. A refill and a lookup of the same slot can share a cycle, and so can a flush and either of them. The bench drives a lookup in the very cycle that a refill installs the entry it needs. It expects a miss there and a hit on the next lookup. It also presents a lookup together with a base-register write, and expects a hit from the old contents followed by a miss. Finally it lands a refill on the flush cycle and judges that the response is still reported while the next lookup misses.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_kind_e;

  localparam int NUM_KINDS = 3;
  localparam int PERM_LSB  = 4;
  localparam int PERM_W    = 6;

  // fetch has priority over store, load is the default
  function automatic acc_kind_e kind_of(input logic fetch, input logic store);
    if (fetch)      return ACC_FETCH;
    else if (store) return ACC_STORE;
    else            return ACC_LOAD;
  endfunction

  // perm[2:0] user {read,write,exec}, perm[5:3] supervisor {read,write,exec}
  function automatic logic perm_allows(input logic [PERM_W-1:0] perm,
                                       input logic sup,
                                       input acc_kind_e kind);
    logic [2:0] grp;
    grp = sup ? perm[5:3] : perm[2:0];
    case (kind)
      ACC_FETCH: return grp[0];
      ACC_STORE: return grp[1];
      default:   return grp[2];
    endcase
  endfunction

endpackage

// File: rtl/tlb_tag_bank.sv
module tlb_tag_bank #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8,
  parameter int TAG_W   = 52
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_set,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid,
  output logic [TAG_W-1:0] rd_tag
);

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q [ENTRIES];

  // flush outranks a same-cycle write
  always_ff @(posedge clk) begin
    if (!rst_n)      valid_q <= '0;
    else if (flush)  valid_q <= '0;
    else if (wr_en)  valid_q[wr_idx] <= wr_set;
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_set) tag_q[wr_idx] <= wr_tag;
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/tlb_frame_store.sv
module tlb_frame_store #(
  parameter int ENTRIES = 256,
  parameter int IDX_W   = 8,
  parameter int FRAME_W = 52
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [FRAME_W-1:0] rd_frame
);

  logic [FRAME_W-1:0] frame_q [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) frame_q[wr_idx] <= wr_frame;
  end

  assign rd_frame = frame_q[rd_idx];

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int ENTRIES    = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lk_valid,
  input  logic [XLEN-1:0] lk_vaddr,
  input  logic            lk_fetch,
  input  logic            lk_store,
  output logic            rsp_hit,
  output logic            rsp_miss,
  output logic [XLEN-1:0] rsp_paddr,
  input  logic            rf_valid,
  input  logic [XLEN-1:0] rf_pte,
  input  logic            rf_supervisor,
  output logic            rf_done,
  output logic            rf_fault,
  output logic [XLEN-1:0] rf_paddr,
  input  logic            ptb_we,
  input  logic [XLEN-1:0] ptb_wdata,
  output logic [XLEN-1:0] ptb_q
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VPN_W = XLEN - PAGE_SHIFT;

  function automatic logic [XLEN-1:0] join_addr(input logic [VPN_W-1:0] frame,
                                                input logic [PAGE_SHIFT-1:0] off);
    return {frame, off};
  endfunction

  function automatic logic [IDX_W-1:0] slot_of(input logic [XLEN-1:0] va);
    return va[PAGE_SHIFT +: IDX_W];
  endfunction

  // named internal events
  acc_kind_e             lk_kind;
  logic [IDX_W-1:0]      lk_idx;
  logic [VPN_W-1:0]      lk_vpn;
  logic                  lookup_hit;
  logic                  lookup_miss;
  logic                  refill_fire;
  logic                  flush_fire;
  logic                  refill_ok;
  logic [PERM_W-1:0]     rf_perm;
  logic [VPN_W-1:0]      rf_frame;

  logic                  pend_v;
  logic [XLEN-1:0]       pend_va;
  acc_kind_e             pend_kind;

  logic [NUM_KINDS-1:0]  bank_valid;
  logic [VPN_W-1:0]      bank_tag [NUM_KINDS];
  logic [VPN_W-1:0]      slot_frame;

  logic                  unused_pte_bits;

  assign lk_kind     = kind_of(lk_fetch, lk_store);
  assign lk_idx      = slot_of(lk_vaddr);
  assign lk_vpn      = lk_vaddr[XLEN-1:PAGE_SHIFT];
  assign lookup_hit  = lk_valid && bank_valid[lk_kind] && (bank_tag[lk_kind] == lk_vpn);
  assign lookup_miss = lk_valid && !lookup_hit;

  assign refill_fire = rf_valid && pend_v;
  assign flush_fire  = ptb_we;
  assign rf_perm     = rf_pte[PERM_LSB +: PERM_W];
  assign rf_frame    = rf_pte[XLEN-1:PAGE_SHIFT];
  assign refill_ok   = perm_allows(rf_perm, rf_supervisor, pend_kind);

  assign unused_pte_bits = ^{rf_pte[PERM_LSB-1:0], rf_pte[PAGE_SHIFT-1:PERM_LSB+PERM_W],
                             ptb_wdata[PAGE_SHIFT-1:0]};

  // one tag bank per access kind
  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_bank
    logic grant;
    assign grant = perm_allows(rf_perm, rf_supervisor, acc_kind_e'(k));

    tlb_tag_bank #(
      .ENTRIES(ENTRIES),
      .IDX_W  (IDX_W),
      .TAG_W  (VPN_W)
    ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush_fire),
      .wr_en   (refill_fire),
      .wr_idx  (slot_of(pend_va)),
      .wr_set  (grant),
      .wr_tag  (pend_va[XLEN-1:PAGE_SHIFT]),
      .rd_idx  (lk_idx),
      .rd_valid(bank_valid[k]),
      .rd_tag  (bank_tag[k])
    );
  end

  tlb_frame_store #(
    .ENTRIES(ENTRIES),
    .IDX_W  (IDX_W),
    .FRAME_W(VPN_W)
  ) u_frames (
    .clk     (clk),
    .wr_en   (refill_fire),
    .wr_idx  (slot_of(pend_va)),
    .wr_frame(rf_frame),
    .rd_idx  (lk_idx),
    .rd_frame(slot_frame)
  );

  // lookup response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_hit   <= lookup_hit;
      rsp_miss  <= lookup_miss;
      rsp_paddr <= lookup_hit ? join_addr(slot_frame, lk_vaddr[PAGE_SHIFT-1:0]) : '0;
    end
  end

  // pending miss: a new miss replaces it, a refill consumes it
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v    <= 1'b0;
      pend_va   <= '0;
      pend_kind <= ACC_LOAD;
    end else if (lookup_miss) begin
      pend_v    <= 1'b1;
      pend_va   <= lk_vaddr;
      pend_kind <= lk_kind;
    end else if (refill_fire) begin
      pend_v    <= 1'b0;
    end
  end

  // refill response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rf_done  <= 1'b0;
      rf_fault <= 1'b0;
      rf_paddr <= '0;
    end else begin
      rf_done  <= refill_fire && refill_ok;
      rf_fault <= refill_fire && !refill_ok;
      rf_paddr <= (refill_fire && refill_ok)
                  ? join_addr(rf_frame, pend_va[PAGE_SHIFT-1:0]) : '0;
    end
  end

  // page-table base
  always_ff @(posedge clk) begin
    if (!rst_n)      ptb_q <= '0;
    else if (ptb_we) ptb_q <= {ptb_wdata[XLEN-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int XLEN       = 64,
  parameter int PAGE_SHIFT = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_valid,
  input logic [XLEN-1:0] lk_vaddr,
  input logic            rsp_hit,
  input logic            rsp_miss,
  input logic [XLEN-1:0] rsp_paddr,
  input logic            rf_valid,
  input logic            rf_done,
  input logic            rf_fault,
  input logic            ptb_we,
  input logic [XLEN-1:0] ptb_q,
  input logic            pend_v
);

  p_hit_miss_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_hit && rsp_miss));

  p_paddr_offset_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_paddr[PAGE_SHIFT-1:0] == $past(lk_vaddr[PAGE_SHIFT-1:0]));

  p_resp_needs_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_hit || rsp_miss) |-> $past(lk_valid));

  p_done_fault_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_done && rf_fault));

  p_refill_needs_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_done || rf_fault) |-> ($past(rf_valid) && $past(pend_v)));

  p_ptb_aligned_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ptb_q[PAGE_SHIFT-1:0] == '0);

  p_no_hit_after_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> !$past(ptb_we, 2));

endmodule

bind tlb_xlate tlb_xlate_chk #(.XLEN(XLEN), .PAGE_SHIFT(PAGE_SHIFT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .lk_valid (lk_valid),
  .lk_vaddr (lk_vaddr),
  .rsp_hit  (rsp_hit),
  .rsp_miss (rsp_miss),
  .rsp_paddr(rsp_paddr),
  .rf_valid (rf_valid),
  .rf_done  (rf_done),
  .rf_fault (rf_fault),
  .ptb_we   (ptb_we),
  .ptb_q    (ptb_q),
  .pend_v   (pend_v)
);

// File: tb/tlb_xlate_tb.sv
module tlb_xlate_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_valid;
  logic [63:0] lk_vaddr;
  logic        lk_fetch;
  logic        lk_store;
  logic        rsp_hit;
  logic        rsp_miss;
  logic [63:0] rsp_paddr;
  logic        rf_valid;
  logic [63:0] rf_pte;
  logic        rf_supervisor;
  logic        rf_done;
  logic        rf_fault;
  logic [63:0] rf_paddr;
  logic        ptb_we;
  logic [63:0] ptb_wdata;
  logic [63:0] ptb_q;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tlb_xlate u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_fetch(lk_fetch), .lk_store(lk_store),
    .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_paddr(rsp_paddr),
    .rf_valid(rf_valid), .rf_pte(rf_pte), .rf_supervisor(rf_supervisor),
    .rf_done(rf_done), .rf_fault(rf_fault), .rf_paddr(rf_paddr),
    .ptb_we(ptb_we), .ptb_wdata(ptb_wdata), .ptb_q(ptb_q)
  );

  // permission bit values
  localparam logic [63:0] P_UX = 64'h010, P_UW = 64'h020, P_UR = 64'h040;
  localparam logic [63:0] P_SX = 64'h080, P_SW = 64'h100, P_SR = 64'h200;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = 0; lk_vaddr = '0; lk_fetch = 0; lk_store = 0;
    rf_valid = 0; rf_pte = '0; rf_supervisor = 0;
    ptb_we = 0; ptb_wdata = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic set_lookup(input logic [63:0] va, input logic f, input logic s);
    lk_valid = 1; lk_vaddr = va; lk_fetch = f; lk_store = s;
  endtask

  task automatic set_refill(input logic [63:0] pte, input logic sup);
    rf_valid = 1; rf_pte = pte; rf_supervisor = sup;
  endtask

  task automatic expect_lookup(input string req, input logic [63:0] va, input logic f,
                               input logic s, input logic hit, input logic [63:0] pa);
    set_lookup(va, f, s);
    step();
    chk({req, " hit"}, {63'd0, rsp_hit}, {63'd0, hit});
    chk({req, " miss"}, {63'd0, rsp_miss}, {63'd0, !hit});
    if (hit) chk({req, " paddr"}, rsp_paddr, pa);
    idle();
  endtask

  task automatic expect_refill(input string req, input logic [63:0] pte, input logic sup,
                               input logic done, input logic fault, input logic [63:0] pa);
    set_refill(pte, sup);
    step();
    chk({req, " done"}, {63'd0, rf_done}, {63'd0, done});
    chk({req, " fault"}, {63'd0, rf_fault}, {63'd0, fault});
    if (done) chk({req, " rf_paddr"}, rf_paddr, pa);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 rsp_hit", {63'd0, rsp_hit}, 64'd0);
    chk("R1 rsp_miss", {63'd0, rsp_miss}, 64'd0);
    chk("R1 rf_done", {63'd0, rf_done}, 64'd0);
    chk("R1 rf_fault", {63'd0, rf_fault}, 64'd0);
    chk("R1 ptb", ptb_q, 64'd0);
    expect_lookup("R1 R5 empty load", 64'h1234, 0, 0, 0, 0);
  endtask

  task automatic t_refill_grant();
    // supervisor read+write, no execute
    expect_refill("R7 done", 64'h0ABCD000 | P_SR | P_SW, 1, 1, 0, 64'h0ABCD234);
    expect_lookup("R2 R4 load hit", 64'h1234, 0, 0, 1, 64'h0ABCD234);
    expect_lookup("R6 store granted", 64'h1FF8, 0, 1, 1, 64'h0ABCDFF8);
    expect_lookup("R6 fetch refused", 64'h1234, 1, 0, 0, 0);
  endtask

  task automatic t_kind_priority();
    expect_lookup("R3 fetch over store", 64'h1234, 1, 1, 0, 0);
    expect_lookup("R3 store tags", 64'h1010, 0, 1, 1, 64'h0ABCD010);
  endtask

  task automatic t_fault();
    expect_lookup("R5 fetch miss", 64'h5000_0008, 1, 0, 0, 0);
    // user read only: fetch faults, load granted
    expect_refill("R7 fault", 64'h00077000 | P_UR, 0, 0, 1, 0);
    expect_lookup("R6 user load", 64'h5000_0008, 0, 0, 1, 64'h00077008);
    expect_lookup("R6 user store refused", 64'h5000_0008, 0, 1, 0, 0);
  endtask

  task automatic t_alias_and_ignored();
    expect_lookup("R2 alias miss", 64'h0010_1234, 0, 0, 0, 0);
    expect_refill("R7 alias done", 64'h00055000 | P_SR, 1, 1, 0, 64'h00055234);
    expect_refill("R8 no pending", 64'h00099000 | 64'h3F0, 1, 0, 0, 0);
    expect_lookup("R8 fetch still refused", 64'h0010_1234, 1, 0, 0, 0);
    expect_lookup("R8 load frame kept", 64'h0010_1234, 0, 0, 1, 64'h00055234);
  endtask

  task automatic t_flush();
    ptb_we = 1; ptb_wdata = 64'hDEAD_BEEF;
    step(); idle();
    chk("R9 ptb aligned", ptb_q, 64'hDEAD_B000);
    expect_lookup("R9 flushed alias", 64'h0010_1234, 0, 0, 0, 0);
    expect_lookup("R9 flushed user", 64'h5000_0008, 0, 0, 0, 0);
  endtask

  task automatic t_lookup_with_refill();
    set_refill(64'h00066000 | P_UR, 0);
    set_lookup(64'h5000_0008, 0, 0);
    step();
    chk("R10 lookup sees old state", {63'd0, rsp_miss}, 64'd1);
    chk("R10 refill done", {63'd0, rf_done}, 64'd1);
    chk("R10 refill paddr", rf_paddr, 64'h00066008);
    idle();
    expect_lookup("R10 later hit", 64'h5000_0008, 0, 0, 1, 64'h00066008);
  endtask

  task automatic t_lookup_with_flush();
    ptb_we = 1; ptb_wdata = 64'h1000;
    set_lookup(64'h5000_0008, 0, 0);
    step();
    chk("R10 hit before flush", {63'd0, rsp_hit}, 64'd1);
    chk("R10 hit paddr", rsp_paddr, 64'h00066008);
    idle();
    expect_lookup("R10 miss after flush", 64'h5000_0008, 0, 0, 0, 0);
  endtask

  task automatic t_flush_with_refill();
    ptb_we = 1; ptb_wdata = 64'h2345;
    set_refill(64'h00066000 | P_UR, 0);
    step();
    chk("R11 done reported", {63'd0, rf_done}, 64'd1);
    chk("R11 paddr", rf_paddr, 64'h00066008);
    chk("R11 ptb", ptb_q, 64'h2000);
    idle();
    expect_lookup("R11 flush wins", 64'h5000_0008, 0, 0, 0, 0);
  endtask

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_refill_grant();
    t_kind_priority();
    t_fault();
    t_alias_and_ignored();
    t_flush();
    t_lookup_with_refill();
    t_lookup_with_flush();
    t_flush_with_refill();
    step();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule